// File: doc/BRIEF.md
# Muon Trigger Word Repacker (24-bit to 32-bit)

This block takes a byte stream in which every trigger word occupies a group of four consecutive byte transfers, one group per 132 ns word slot. Only the first three bytes of a group are payload; the fourth is dropped. The payload bytes are concatenated into a continuous stream and cut into 32-bit output words. Four 24-bit input words therefore fill exactly three output words, with no bits wasted.

An event begins with a one-cycle start pulse that carries a two-bit word-count select. The select chooses 0, 10, 20 or 30 input words for the event. The last output word of the event carries an end flag. If the payload does not fill that word, its unused upper bytes are zero and a partial flag is raised. An event with zero words still yields one empty output word, which carries both flags. Output words pass through a short queue with valid/ready flow control. The input has no back-pressure, so downstream must not stall for long.

The control path is a three-state machine. IDLE waits for the start pulse. On a start pulse with a non-zero count, IDLE goes to PAYLOAD. With a zero count it stays in IDLE and emits the empty word. PAYLOAD accepts the three payload bytes of a group and then goes to SPARE. SPARE accepts the dropped byte and then either returns to PAYLOAD, if words remain, or falls back to IDLE.

Top module: `repack24`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is low until the first event produces a word.
- R2: Within each group of four bytes accepted with `in_valid`, bytes 0, 1 and 2 are payload, taken least significant first (byte 0 is bits 7:0 of the 24-bit word). Byte 3 never appears in the output.
- R3: Payload byte k of an event, counted from 0 across all its words, appears in output word k/4 at bits 8*(k%4)+7 down to 8*(k%4). Four input words thus yield exactly three output words.
- R4: `word_sel` is sampled with the start pulse and encodes the words per event as 00=0, 01=10, 10=20, 11=30. The event yields ceil(3*N/4) output words, or one word when N is 0.
- R5: `out_last` is high on the final output word of each event and low on every other word.
- R6: When the final word holds fewer than four payload bytes, its unused upper bytes are zero and `out_partial` is high. `out_partial` is low on every full word.
- R7: A start pulse selecting zero words produces one word with data 0, `out_last` high and `out_partial` high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_last` and `out_partial` hold their values.
- R9: Bytes presented while idle (no event open) are ignored. A start pulse while an event is still open is ignored and does not change that event.
- R10: No output word is lost or duplicated as long as `out_ready` is never low for more than three consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Incoming byte of the current group |
| in_valid | input | 1 | `in_byte` is presented this cycle |
| sof | input | 1 | One-cycle start-of-event pulse |
| word_sel | input | 2 | Words-per-event select, sampled with `sof` |
| out_data | output | 32 | Packed output word |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream accepts the output word |
| out_last | output | 1 | Output word ends the event |
| out_partial | output | 1 | Output word is zero-padded |

## Verification
The assertions assume three things about the inputs. Downstream never stalls long enough to overfill the two-entry output queue. A new start pulse arrives only after the previous event's last group is complete. Zero-word events are spaced so that their empty words do not arrive faster than the queue drains. The stimulus drives at most one byte per cycle, with optional one-cycle gaps inside groups. It caps every low stretch of `out_ready` at three cycles and waits four cycles after each zero-word start. Any start pulse sent mid-event is deliberately ignored by the design, so it does not count against the second assumption.

// File: rtl/repack_pkg.sv
package repack_pkg;

    // Control states of the byte-group sequencer
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,  // waiting for a start-of-event pulse
        ST_PAYLOAD = 2'd1,  // accepting the payload bytes of a group
        ST_SPARE   = 2'd2   // accepting the dropped byte(s) of a group
    } rp_state_t;

endpackage

// File: rtl/rp_fsm.sv
module rp_fsm
    import repack_pkg::*;
#(
    parameter int GROUP_BYTES   = 4,
    parameter int PAYLOAD_BYTES = 3,
    parameter int WORD_STEP     = 10,
    parameter int SEL_W         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             sof,
    input  logic [SEL_W-1:0] word_sel,
    output logic             take_byte,
    output logic             final_byte,
    output logic             empty_evt,
    output logic             idle
);

    localparam int LANE_W    = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1;
    localparam int MAX_WORDS = WORD_STEP * ((1 << SEL_W) - 1);
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);
    localparam logic [LANE_W-1:0] LAST_PAY  = LANE_W'(PAYLOAD_BYTES - 1);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(GROUP_BYTES - 1);

    rp_state_t         state_q, state_d;
    logic [LANE_W-1:0] lane_q, lane_d;
    logic [CNT_W-1:0]  left_q, left_d;
    logic [CNT_W-1:0]  req_words;

    assign req_words = CNT_W'(WORD_STEP) * CNT_W'(word_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            lane_q  <= lane_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        lane_d  = lane_q;
        left_d  = left_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sof && (req_words != '0)) begin
                    state_d = ST_PAYLOAD;
                    lane_d  = '0;
                    left_d  = req_words;
                end
            end
            ST_PAYLOAD: begin
                if (in_valid) begin
                    lane_d = lane_q + 1'b1;
                    if (lane_q == LAST_PAY) begin
                        left_d  = left_q - 1'b1;
                        state_d = ST_SPARE;
                    end
                end
            end
            ST_SPARE: begin
                if (in_valid) begin
                    if (lane_q == LAST_LANE) begin
                        lane_d  = '0;
                        state_d = (left_q == '0) ? ST_IDLE : ST_PAYLOAD;
                    end else begin
                        lane_d = lane_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_byte  = 1'b0;
        final_byte = 1'b0;
        empty_evt  = 1'b0;
        idle       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle      = 1'b1;
                empty_evt = sof && (req_words == '0);
            end
            ST_PAYLOAD: begin
                take_byte  = in_valid;
                final_byte = in_valid && (lane_q == LAST_PAY)
                             && (left_q == CNT_W'(1));
            end
            ST_SPARE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/rp_acc.sv
module rp_acc #(
    parameter int BYTE_W    = 8,
    parameter int OUT_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BYTE_W-1:0]           in_byte,
    input  logic                        take_byte,
    input  logic                        final_byte,
    input  logic                        empty_evt,
    output logic                        push,
    output logic [OUT_BYTES*BYTE_W-1:0] push_data,
    output logic                        push_last,
    output logic                        push_partial
);

    localparam int FILL_W = (OUT_BYTES > 1) ? $clog2(OUT_BYTES) : 1;

    logic [OUT_BYTES-1:0][BYTE_W-1:0] acc_q, merged;
    logic [FILL_W-1:0]                fill_q;
    logic                             filled;

    // Drop the incoming byte into the lane selected by the fill count
    generate
        for (genvar g = 0; g < OUT_BYTES; g++) begin : g_lane
            assign merged[g] = (take_byte && (fill_q == FILL_W'(g))) ? in_byte : acc_q[g];
        end
    endgenerate

    assign filled       = (fill_q == FILL_W'(OUT_BYTES - 1));
    assign push         = empty_evt || (take_byte && (filled || final_byte));
    assign push_data    = empty_evt ? '0 : merged;
    assign push_last    = empty_evt || final_byte;
    assign push_partial = empty_evt || !filled;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            fill_q <= '0;
        end else if (take_byte) begin
            if (push) begin
                acc_q  <= '0;
                fill_q <= '0;
            end else begin
                acc_q  <= merged;
                fill_q <= fill_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rp_outq.sv
module rp_outq #(
    parameter int W     = 34,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         pop,
    output logic [W-1:0] out_word,
    output logic         out_valid,
    output logic         full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] count_q;
    logic             wr_en, rd_en;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count_q == CNT_W'(DEPTH));
    assign out_valid = (count_q != '0);
    assign out_word  = mem_q[rd_q];
    assign rd_en     = pop && out_valid;
    assign wr_en     = push && (!full || rd_en);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (wr_en) begin
                mem_q[wr_q] <= push_word;
                wr_q        <= bump(wr_q);
            end
            if (rd_en) rd_q <= bump(rd_q);
            if (wr_en && !rd_en)      count_q <= count_q + 1'b1;
            else if (rd_en && !wr_en) count_q <= count_q - 1'b1;
        end
    end

endmodule

// File: rtl/repack24.sv
module repack24 #(
    parameter int BYTE_W        = 8,
    parameter int GROUP_BYTES   = 4,
    parameter int PAYLOAD_BYTES = 3,
    parameter int OUT_BYTES     = 4,
    parameter int WORD_STEP     = 10,
    parameter int SEL_W         = 2,
    parameter int QUEUE_DEPTH   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BYTE_W-1:0]           in_byte,
    input  logic                        in_valid,
    input  logic                        sof,
    input  logic [SEL_W-1:0]            word_sel,
    output logic [OUT_BYTES*BYTE_W-1:0] out_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic                        out_last,
    output logic                        out_partial
);

    localparam int OUT_W  = OUT_BYTES * BYTE_W;
    localparam int WORD_W = OUT_W + 2;

    logic              take_byte, final_byte, empty_evt, fsm_idle;
    logic              q_push, q_pop, q_full;
    logic              push_last, push_partial;
    logic [OUT_W-1:0]  push_data;
    logic [WORD_W-1:0] q_out;

    rp_fsm #(
        .GROUP_BYTES  (GROUP_BYTES),
        .PAYLOAD_BYTES(PAYLOAD_BYTES),
        .WORD_STEP    (WORD_STEP),
        .SEL_W        (SEL_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sof       (sof),
        .word_sel  (word_sel),
        .take_byte (take_byte),
        .final_byte(final_byte),
        .empty_evt (empty_evt),
        .idle      (fsm_idle)
    );

    rp_acc #(
        .BYTE_W   (BYTE_W),
        .OUT_BYTES(OUT_BYTES)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_byte     (in_byte),
        .take_byte   (take_byte),
        .final_byte  (final_byte),
        .empty_evt   (empty_evt),
        .push        (q_push),
        .push_data   (push_data),
        .push_last   (push_last),
        .push_partial(push_partial)
    );

    assign q_pop = out_valid && out_ready;

    rp_outq #(
        .W    (WORD_W),
        .DEPTH(QUEUE_DEPTH)
    ) u_outq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_word({push_last, push_partial, push_data}),
        .pop      (q_pop),
        .out_word (q_out),
        .out_valid(out_valid),
        .full     (q_full)
    );

    assign out_last    = q_out[OUT_W+1];
    assign out_partial = q_out[OUT_W];
    assign out_data    = q_out[OUT_W-1:0];

endmodule

// File: rtl/repack24_chk.sv
module repack24_chk #(
    parameter int OUT_W  = 32,
    parameter int BYTE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof,
    input logic             out_ready,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             out_last,
    input logic             out_partial,
    input logic             fsm_idle,
    input logic             q_push,
    input logic             q_full,
    input logic             q_pop
);

    // R8: a stalled word stays put
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_last) && $stable(out_partial));

    // R6: a padded word has its top byte zero
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_partial |-> out_data[OUT_W-1 -: BYTE_W] == '0);

    // R5: only the closing word of an event may be padded
    a_r5_partial_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_partial |-> out_last);

    // R10: the queue never receives a word it cannot hold
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_push && q_full |-> q_pop);

    // R9: with no event open and no start pulse, nothing is produced
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle && !sof |-> !q_push);

endmodule

bind repack24 repack24_chk #(
    .OUT_W (OUT_W),
    .BYTE_W(BYTE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof        (sof),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_partial(out_partial),
    .fsm_idle   (fsm_idle),
    .q_push     (q_push),
    .q_full     (q_full),
    .q_pop      (q_pop)
);

// File: tb/repack24_bench.sv
`timescale 1ns/1ps
module repack24_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        sof = 1'b0;
    logic [1:0]  word_sel = '0;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_last;
    logic        out_partial;

    always #2.5 clk = ~clk;

    repack24 u_repack24 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_byte    (in_byte),
        .in_valid   (in_valid),
        .sof        (sof),
        .word_sel   (word_sel),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_last   (out_last),
        .out_partial(out_partial)
    );

    typedef struct {
        logic [31:0] data;
        bit          last;
        bit          partial;
        bit          zero;
    } exp_t;

    exp_t        expq[$];
    int          cntq[$];
    exp_t        mon_e;
    int          mon_cnt;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    bit          mon_on = 1'b0;
    bit          stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          lowrun = 0;
    bit          held_v = 1'b0;
    logic [31:0] held_d = '0;
    int          ev_words = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [23:0] mk_word(input int seed, input int j);
        return 24'(seed * 32'h1F3A7 + j * 32'hB5C1 + 32'h3C0D5);
    endfunction

    // Monitor: drives ready, pops the scoreboard, compares
    always @(negedge clk) begin
        if (mon_on) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (stall_en && !lfsr[0] && lowrun < 3) begin
                out_ready = 1'b0;
                lowrun++;
            end else begin
                out_ready = 1'b1;
                lowrun = 0;
            end
            if (held_v)  // R8: stalled word must not move
                chk(out_valid === 1'b1 && out_data === held_d, "R8 stalled word held", out_data, held_d);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R10 unexpected extra word", out_data, 32'h0);
                end else begin
                    mon_e = expq.pop_front();
                    chk(out_data === mon_e.data,
                        mon_e.zero ? "R7 empty event word" : "R2 R3 packed payload",
                        out_data, mon_e.data);
                    chk(out_last === mon_e.last, "R5 end flag", 32'(out_last), 32'(mon_e.last));
                    chk(out_partial === mon_e.partial, "R6 partial flag", 32'(out_partial), 32'(mon_e.partial));
                end
                ev_words++;
                if (out_last) begin
                    if (cntq.size() != 0) begin
                        mon_cnt = cntq.pop_front();
                        chk(ev_words == mon_cnt, "R4 words per event", 32'(ev_words), 32'(mon_cnt));
                    end
                    ev_words = 0;
                end
            end
            held_v = out_valid && !out_ready;
            held_d = out_data;
        end
    end

    // Driver: queue expected words, then play the event
    task automatic send_event(input int sel, input int seed, input bit gaps, input bit bad_sof);
        int          n;
        int          nb;
        int          nw;
        logic [7:0]  pl[$];
        logic [23:0] w;
        logic [31:0] d;
        exp_t        e;
        n = sel * 10;
        if (n == 0) begin
            e.data = '0; e.last = 1'b1; e.partial = 1'b1; e.zero = 1'b1;
            expq.push_back(e);
            cntq.push_back(1);
        end else begin
            for (int j = 0; j < n; j++) begin
                w = mk_word(seed, j);
                pl.push_back(w[7:0]);
                pl.push_back(w[15:8]);
                pl.push_back(w[23:16]);
            end
            nb = 3 * n;
            nw = (nb + 3) / 4;
            for (int k = 0; k < nw; k++) begin
                d = '0;
                for (int b = 0; b < 4; b++)
                    if (4 * k + b < nb) d[8*b +: 8] = pl[4*k + b];
                e.data = d;
                e.last = (k == nw - 1);
                e.partial = (4 * k + 4 > nb);
                e.zero = 1'b0;
                expq.push_back(e);
            end
            cntq.push_back(nw);
        end
        @(negedge clk);
        sof = 1'b1;
        word_sel = 2'(sel);
        @(negedge clk);
        sof = 1'b0;
        word_sel = 2'(sel + 1);
        if (n == 0) begin
            repeat (4) @(negedge clk);
            return;
        end
        for (int j = 0; j < n; j++) begin
            w = mk_word(seed, j);
            for (int b = 0; b < 4; b++) begin
                if (gaps && b == 1) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                in_byte = (b < 3) ? w[8*b +: 8] : (8'hA5 ^ 8'(j));
                if (bad_sof && j == 2 && b == 0) begin
                    sof = 1'b1;      // R9: ignored mid-event
                    word_sel = 2'd3;
                end else begin
                    sof = 1'b0;
                end
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        sof = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired, words pending=%0d", expq.size());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1 valid low in reset", 32'(out_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 valid low after reset", 32'(out_valid), 32'h0);
        mon_on = 1'b1;

        // R9: stray bytes with no open event
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1;
            in_byte = 8'(8'h30 + i);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(out_valid === 1'b0, "R9 stray bytes ignored", 32'(out_valid), 32'h0);

        // R4 each count setting, free-running output
        send_event(1, 1, 1'b0, 1'b0);
        send_event(2, 2, 1'b0, 1'b0);
        send_event(3, 3, 1'b0, 1'b0);
        send_event(0, 4, 1'b0, 1'b0);   // R7
        send_event(3, 5, 1'b1, 1'b0);

        // R8 R10 with downstream stalls
        stall_en = 1'b1;
        send_event(1, 6, 1'b0, 1'b0);
        send_event(3, 7, 1'b0, 1'b0);
        send_event(0, 8, 1'b0, 1'b0);
        send_event(0, 9, 1'b0, 1'b0);
        send_event(2, 10, 1'b1, 1'b0);
        send_event(1, 11, 1'b0, 1'b1);  // R9 start pulse mid-event
        send_event(3, 12, 1'b1, 1'b0);
        stall_en = 1'b0;

        for (int g = 0; g < 2000 && expq.size() != 0; g++) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R10 every word delivered", 32'(expq.size()), 32'h0);
        chk(cntq.size() == 0, "R4 every event closed", 32'(cntq.size()), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule